// File: doc/BRIEF.md
# Match-Compare System Timer

This block is a system timer that sits on a simple 32-bit register bus with an address, a write enable, write data and combinational read data. It holds one free-running up-counter, four compare registers, a sticky per-channel flag register, a per-channel interrupt mask and a one-bit watchdog arm. Software programs a compare value. When the counter steps onto that value, the channel's flag sets and stays set until software clears it. Each channel drives its own interrupt line, and that line is gated by the channel's mask bit.

The counter steps only on cycles where the tick-enable input is high, which lets a slow timebase drive a fast bus clock. Compare is a plain equality test against a counter that wraps, so a compare value the counter has already passed fires only after a full wrap. Once software arms the watchdog it cannot disarm it until reset. From then on, every match on channel 3 produces a one-cycle reset request.

Top module: `os_match_timer`

## Requirements
- R1: After reset, the counter, all flags, the interrupt mask and the watchdog arm read 0, all `irqOut` bits are 0 and `wdtResetReq` is 0.
- R2: The counter is read and written at offset 0x10. A counter write replaces that cycle's increment, even when `tickEn` is high.
- R3: The counter adds 1 on each clock edge where `tickEn` is high and no counter write occurs. It holds otherwise and wraps from 0xFFFFFFFF to 0.
- R4: Compare registers 0 to 3 sit at offsets 0x00, 0x04, 0x08 and 0x0C. Flag bit i of the status word at 0x14 sets on the edge where the incremented counter equals compare register i, and it stays set afterwards.
- R5: `irqOut[i]` is 1 exactly while flag bit i and bit i of the mask word at 0x1C are both 1.
- R6: Writing the status word at 0x14 clears each flag whose data bit is 1 and leaves flags with a 0 data bit unchanged.
- R7: When a flag clear and a new match on the same channel meet in one cycle, the flag is 1 afterwards.
- R8: A compare value below the counter fires only after the counter wraps and climbs back to it.
- R9: Reads of offsets that are not one of the eight word-aligned addresses 0x00 to 0x1C return 0, and writes to them change no register.
- R10: Bit 0 of the word at 0x18 is the watchdog arm. Writing 1 sets it. Once set, writes cannot clear it until reset.
- R11: While the watchdog is armed, a channel 3 match raises `wdtResetReq` for exactly one cycle, on the same edge that sets flag 3. While it is disarmed, `wdtResetReq` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Counter step enable |
| busAddr | input | 8 | Byte address |
| busWe | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from address |
| irqOut | output | 4 | Per-channel interrupt, flag AND mask |
| wdtResetReq | output | 1 | One-cycle watchdog reset request |

## Verification
All register writes land on the clock edge that samples the write strobe. Read data follows the address combinationally, so the bench reads one time step after setting the address at a falling edge. Flags, the counter and the interrupt lines settle on the same rising edge as the tick or write that causes them, and the bench samples them at the following falling edge. The watchdog request is due on the rising edge of the matching tick and must be gone one edge later, so the bench samples it 1 ns after each of those two rising edges.

// File: rtl/ostimer_pkg.sv
package ostimer_pkg;
  localparam int NUM_CH = 4;
  localparam int WDT_CH = NUM_CH - 1;
  localparam int SEL_W  = 3;

  // strobes from decode to datapath
  typedef struct packed {
    logic [NUM_CH-1:0] wrMatch;
    logic              wrCount;
    logic              wrStatus;
    logic              wrWdt;
    logic              wrIrqEn;
    logic              rdValid;
    logic [SEL_W-1:0]  rdSel;
  } ctrl_t;
endpackage

// File: rtl/ostimer_ctrl.sv
module ostimer_ctrl
  import ostimer_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output ctrl_t             ctrl
);
  localparam int WORDS = 8;
  localparam logic [ADDR_W-1:0] MAP_END = ADDR_W'(WORDS * 4);

  logic mapped;
  logic [SEL_W-1:0] wordIdx;

  assign mapped  = (busAddr < MAP_END) && (busAddr[1:0] == 2'b00);
  assign wordIdx = busAddr[SEL_W+1:2];

  always_comb begin
    ctrl         = '0;
    ctrl.rdValid = mapped;
    ctrl.rdSel   = wordIdx;
    if (busWe && mapped) begin
      case (wordIdx)
        3'd4:    ctrl.wrCount  = 1'b1;
        3'd5:    ctrl.wrStatus = 1'b1;
        3'd6:    ctrl.wrWdt    = 1'b1;
        3'd7:    ctrl.wrIrqEn  = 1'b1;
        default: ctrl.wrMatch[wordIdx[1:0]] = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/ostimer_dp.sv
module ostimer_dp
  import ostimer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  ctrl_t             ctrl,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [NUM_CH-1:0] irqOut,
  output logic              wdtReq
);
  logic [DATA_W-1:0] countQ;
  logic [DATA_W-1:0] nextCount;
  logic [DATA_W-1:0] matchQ [NUM_CH];
  logic [NUM_CH-1:0] statusQ, irqEnQ, hit, clrMask;
  logic              wdtEnQ, wdtReqQ, advance;

  assign advance   = tickEn && !ctrl.wrCount;
  assign nextCount = countQ + DATA_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN)              countQ <= '0;
    else if (ctrl.wrCount)  countQ <= wdata;
    else if (advance)       countQ <= nextCount;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    always_ff @(posedge clk) begin
      if (!rstN)                   matchQ[ch] <= '0;
      else if (ctrl.wrMatch[ch])   matchQ[ch] <= wdata;
    end
    assign hit[ch] = advance && (nextCount == matchQ[ch]);
  end

  assign clrMask = ctrl.wrStatus ? wdata[NUM_CH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      irqEnQ  <= '0;
      wdtEnQ  <= 1'b0;
      wdtReqQ <= 1'b0;
    end else begin
      statusQ <= (statusQ & ~clrMask) | hit;
      if (ctrl.wrIrqEn) irqEnQ <= wdata[NUM_CH-1:0];
      wdtEnQ  <= wdtEnQ | (ctrl.wrWdt & wdata[0]);
      wdtReqQ <= wdtEnQ & hit[WDT_CH];
    end
  end

  assign irqOut = statusQ & irqEnQ;
  assign wdtReq = wdtReqQ;

  always_comb begin
    rdata = '0;
    if (ctrl.rdValid) begin
      case (ctrl.rdSel)
        3'd4:    rdata = countQ;
        3'd5:    rdata = DATA_W'(statusQ);
        3'd6:    rdata = DATA_W'(wdtEnQ);
        3'd7:    rdata = DATA_W'(irqEnQ);
        default: rdata = matchQ[ctrl.rdSel[1:0]];
      endcase
    end
  end
endmodule

// File: rtl/os_match_timer.sv
module os_match_timer
  import ostimer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [NUM_CH-1:0] irqOut,
  output logic              wdtResetReq
);
  ctrl_t ctrl;

  ostimer_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .busAddr (busAddr),
    .busWe   (busWe),
    .ctrl    (ctrl)
  );

  ostimer_dp #(.DATA_W(DATA_W)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .tickEn (tickEn),
    .ctrl   (ctrl),
    .wdata  (busWdata),
    .rdata  (busRdata),
    .irqOut (irqOut),
    .wdtReq (wdtResetReq)
  );
endmodule

// File: rtl/os_match_timer_chk.sv
module os_match_timer_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic [DATA_W-1:0] busWdata,
  input logic [3:0]        irqOut,
  input logic              wdtResetReq
);
  logic statusWr, maskWr;
  assign statusWr = busWe && (busAddr == ADDR_W'(8'h14));
  assign maskWr   = busWe && (busAddr == ADDR_W'(8'h1C));

  // R11: request never lasts two cycles
  p_wdt_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    wdtResetReq |=> !wdtResetReq);

  // R4: raised interrupts stay up unless software touches flags or mask
  p_irq_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!statusWr && !maskWr) |=> ((irqOut & $past(irqOut)) == $past(irqOut)));

  // R6: clearing flag 0 without a tick drops its interrupt
  p_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (statusWr && busWdata[0] && !tickEn) |=> !irqOut[0]);

  // R3: no tick and no write means nothing moves
  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !busWe) |=> ($stable(irqOut) && !wdtResetReq));

  // R9: unmapped writes leave outputs alone
  p_unmapped_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && (busAddr >= ADDR_W'(8'h20)) && !tickEn) |=> $stable(irqOut));
endmodule

bind os_match_timer os_match_timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .tickEn      (tickEn),
  .busAddr     (busAddr),
  .busWe       (busWe),
  .busWdata    (busWdata),
  .irqOut      (irqOut),
  .wdtResetReq (wdtResetReq)
);

// File: tb/os_match_timer_tb_top.sv
`timescale 1ns/1ps
module os_match_timer_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [3:0]  irqOut;
  logic        wdtResetReq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  localparam logic [7:0] A_M0 = 8'h00, A_M1 = 8'h04, A_M2 = 8'h08, A_M3 = 8'h0C;
  localparam logic [7:0] A_CNT = 8'h10, A_STS = 8'h14, A_WDT = 8'h18, A_IEN = 8'h1C;

  always #2.5 clk = ~clk;

  os_match_timer dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut), .wdtResetReq(wdtResetReq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tickEn = 1'b1;
      @(negedge clk); tickEn = 1'b0;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    busRead(A_CNT, d); check("R1 counter", d, 0);
    busRead(A_STS, d); check("R1 status", d, 0);
    busRead(A_IEN, d); check("R1 mask", d, 0);
    busRead(A_WDT, d); check("R1 wdt arm", d, 0);
    check("R1 irqOut", {28'd0, irqOut}, 0);
    check("R1 wdtResetReq", {31'd0, wdtResetReq}, 0);
  endtask

  task automatic t_counter();
    logic [31:0] d;
    busWrite(A_M0, 32'd100); busWrite(A_M1, 32'd200);
    busWrite(A_M2, 32'd300); busWrite(A_M3, 32'd400);
    busWrite(A_CNT, 32'h1234);
    busRead(A_CNT, d); check("R2 counter write", d, 32'h1234);
    repeat (3) @(negedge clk);
    busRead(A_CNT, d); check("R3 hold without tick", d, 32'h1234);
    tick(3);
    busRead(A_CNT, d); check("R3 three ticks", d, 32'h1237);
    @(negedge clk);
    busWe = 1'b1; busAddr = A_CNT; busWdata = 32'h50; tickEn = 1'b1;
    @(negedge clk);
    busWe = 1'b0; tickEn = 1'b0;
    busRead(A_CNT, d); check("R2 write beats tick", d, 32'h50);
    busWrite(A_CNT, 32'hFFFF_FFFF);
    tick(1);
    busRead(A_CNT, d); check("R3 wrap", d, 0);
  endtask

  task automatic t_match();
    logic [31:0] d;
    busWrite(A_CNT, 32'd98);
    busWrite(A_STS, 32'hF);
    tick(1);
    busRead(A_STS, d); check("R4 not yet", d & 32'h1, 0);
    tick(1);
    busRead(A_STS, d); check("R4 flag on match", d & 32'h1, 1);
    tick(2);
    busRead(A_STS, d); check("R4 sticky", d & 32'h1, 1);
    check("R5 masked", {28'd0, irqOut}, 0);
    busWrite(A_IEN, 32'h1);
    check("R5 enabled", {28'd0, irqOut}, 32'h1);
    busWrite(A_IEN, 32'h0);
    check("R5 disabled again", {28'd0, irqOut}, 0);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    busWrite(A_STS, 32'h0);
    busRead(A_STS, d); check("R6 zero keeps", d & 32'h1, 1);
    busWrite(A_STS, 32'h1);
    busRead(A_STS, d); check("R6 one clears", d & 32'h1, 0);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    busWrite(A_CNT, 32'd199);
    busWrite(A_STS, 32'hF);
    @(negedge clk);
    busWe = 1'b1; busAddr = A_STS; busWdata = 32'h2; tickEn = 1'b1;
    @(negedge clk);
    busWe = 1'b0; tickEn = 1'b0;
    busRead(A_STS, d); check("R7 match beats clear", d, 32'h2);
  endtask

  task automatic t_wrap();
    logic [31:0] d;
    busWrite(A_M2, 32'd50);
    busWrite(A_CNT, 32'd60);
    busWrite(A_STS, 32'hF);
    tick(5);
    busRead(A_STS, d); check("R8 behind counter", d & 32'h4, 0);
    busWrite(A_CNT, 32'hFFFF_FFFE);
    tick(51);
    busRead(A_STS, d); check("R8 just before", d & 32'h4, 0);
    tick(1);
    busRead(A_STS, d); check("R8 after wrap", d & 32'h4, 32'h4);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    busWrite(8'h20, 32'hDEAD);
    busWrite(8'h01, 32'hBEEF);
    busRead(8'h20, d); check("R9 read 0x20", d, 0);
    busRead(8'h02, d); check("R9 misaligned", d, 0);
    busRead(A_M0, d); check("R9 compare 0 intact", d, 32'd100);
  endtask

  task automatic t_wdt();
    logic [31:0] d;
    busWrite(A_CNT, 32'd398);
    busWrite(A_STS, 32'hF);
    tick(1);
    @(negedge clk); tickEn = 1'b1;
    @(posedge clk); #1 check("R11 disarmed", {31'd0, wdtResetReq}, 0);
    @(negedge clk); tickEn = 1'b0;
    busWrite(A_WDT, 32'h1);
    busRead(A_WDT, d); check("R10 armed", d, 1);
    busWrite(A_WDT, 32'h0);
    busRead(A_WDT, d); check("R10 stays armed", d, 1);
    busWrite(A_CNT, 32'd398);
    busWrite(A_STS, 32'hF);
    tick(1);
    @(negedge clk); tickEn = 1'b1;
    @(posedge clk); #1 check("R11 pulse", {31'd0, wdtResetReq}, 1);
    @(negedge clk); tickEn = 1'b0;
    @(posedge clk); #1 check("R11 one cycle", {31'd0, wdtResetReq}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_counter();
    t_match();
    t_w1c();
    t_collide();
    t_wrap();
    t_unmapped();
    t_wdt();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule